// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. Both phase inputs come in asynchronous to the system clock. A short synchroniser chain brings each one into the clock domain. The block then compares each channel with its level one clock earlier, so it sees a level change on each channel on its own. It decodes both rising and falling edges.

When exactly one channel changes, the block works out the step direction from two things: which channel moved, and whether the two levels match after the change. It does not use a full old-state/new-state lookup. It then moves the position by one in that direction. In the same clock cycle it raises a one-cycle step pulse and updates the direction output. If both channels change in the same sample, the transition is not a valid Gray step. In that case the position stays where it is and the block raises a one-cycle error pulse. The inputs are expected to be already clean, so the block does no filtering.

Top module: `quad_position_decoder`

## Requirements
- R1: The channel state is written {A,B}, with A as the high bit. Forward motion visits 00, 10, 11, 01 and then 00 again. Reverse motion visits the same states in the opposite order.
- R2: When only B changes and A equals B afterwards, the position rises by one and `dir_fwd` is 1.
- R3: When only B changes and A differs from B afterwards, the position falls by one and `dir_fwd` is 0.
- R4: When only A changes and A equals B afterwards, the position falls by one and `dir_fwd` is 0.
- R5: When only A changes and A differs from B afterwards, the position rises by one and `dir_fwd` is 1.
- R6: Rising and falling edges of both channels are all counted. One full forward cycle of four states moves the position by exactly +4.
- R7: When both channels change in the same sample, `phase_err` pulses for one cycle and `step` stays low. The position and `dir_fwd` keep their values.
- R8: The position is a POS_W-bit two's-complement count (32 bits by default). It wraps on overflow and on underflow and never saturates.
- R9: Synchronous reset sets the position to 0 and `dir_fwd` to 1. Releasing reset while the inputs are high produces no step.
- R10: A single-channel change reaches the outputs on the third rising clock edge after the input was sampled. On that edge `step` pulses for exactly one cycle, and `position` and `dir_fwd` update together with it. Between steps, `dir_fwd` holds its value.
- R11: While neither channel changes, `step` and `phase_err` stay low and the position holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_a | input | 1 | Encoder phase A (asynchronous) |
| ch_b | input | 1 | Encoder phase B (asynchronous) |
| position | output | POS_W | Signed position count |
| step | output | 1 | One-cycle pulse on each counted step |
| dir_fwd | output | 1 | Direction of the last step, 1 for forward |
| phase_err | output | 1 | One-cycle pulse when both channels change together |

## Verification
A stale stored previous level would show up as a missing step, a spurious step, or a step with the wrong sign. Each of these reaches `position` and `step` exactly three clocks after the input change that exposes it. A wrong direction decision would corrupt the count at the very step that uses it, and a bad wrap would show at the single step that crosses the extreme of the count range. The sweep therefore drives every transition from every one of the four states, including the double-change cases. It also runs the count across both wrap points, and it checks the outputs in the cycle before, at and after each expected update.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

   typedef enum logic {
      QD_REV = 1'b0,
      QD_FWD = 1'b1
   } qd_dir_e;

   typedef struct packed {
      logic a;
      logic b;
   } qd_lvl_t;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qdec_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
   import qdec_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  qd_lvl_t lvl,
   output logic    chg_a,
   output logic    chg_b
);

   qd_lvl_t prev;

   // At reset the stored level follows the live input, so release is quiet.
   always_ff @(posedge clk) begin
      prev <= lvl;
   end

   assign chg_a = (lvl.a ^ prev.a) & ~rst;
   assign chg_b = (lvl.b ^ prev.b) & ~rst;

endmodule

// File: rtl/qdec_step_logic.sv
module qdec_step_logic
   import qdec_pkg::*;
(
   input  logic    chg_a,
   input  logic    chg_b,
   input  qd_lvl_t lvl,
   output logic    step_req,
   output logic    err_req,
   output qd_dir_e dir_req
);

   logic same;

   always_comb begin
      same     = (lvl.a == lvl.b);
      step_req = chg_a ^ chg_b;
      err_req  = chg_a & chg_b;
      // B moving: equal levels mean forward. A moving: equal levels mean reverse.
      if (chg_b) dir_req = same ? QD_FWD : QD_REV;
      else       dir_req = same ? QD_REV : QD_FWD;
   end

endmodule

// File: rtl/qdec_position.sv
module qdec_position
   import qdec_pkg::*;
#(
   parameter int POS_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_req,
   input  logic             err_req,
   input  qd_dir_e          dir_req,
   output logic [POS_W-1:0] pos,
   output logic             step,
   output logic             err,
   output qd_dir_e          dir_q
);

   localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

   if (POS_W < 2) begin : g_bad_width
      $error("qdec_position: POS_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos   <= '0;
         dir_q <= QD_FWD;
         step  <= 1'b0;
         err   <= 1'b0;
      end else begin
         step <= step_req;
         err  <= err_req;
         if (step_req) begin
            dir_q <= dir_req;
            pos   <= (dir_req == QD_FWD) ? pos + ONE : pos - ONE;
         end
      end
   end

   p_step_moves_r10: assert property (@(posedge clk) disable iff (rst)
      step |-> (pos == ((dir_q == QD_FWD) ? $past(pos) + ONE : $past(pos) - ONE)));

   p_hold_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      !step |-> (pos == $past(pos)));

   p_dir_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !step |-> (dir_q == $past(dir_q)));

   p_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(step && err));

endmodule

// File: rtl/quad_position_decoder.sv
module quad_position_decoder
   import qdec_pkg::*;
#(
   parameter int POS_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ch_a,
   input  logic             ch_b,
   output logic [POS_W-1:0] position,
   output logic             step,
   output logic             dir_fwd,
   output logic             phase_err
);

   qd_lvl_t lvl;
   logic    chg_a, chg_b, step_req, err_req;
   qd_dir_e dir_req, dir_q;

   qdec_sync #(.STAGES(SYNC_STAGES)) u_sync_a (.clk(clk), .d(ch_a), .q(lvl.a));
   qdec_sync #(.STAGES(SYNC_STAGES)) u_sync_b (.clk(clk), .d(ch_b), .q(lvl.b));

   qdec_edge u_edge (
      .clk(clk), .rst(rst), .lvl(lvl), .chg_a(chg_a), .chg_b(chg_b)
   );

   qdec_step_logic u_dec (
      .chg_a(chg_a), .chg_b(chg_b), .lvl(lvl),
      .step_req(step_req), .err_req(err_req), .dir_req(dir_req)
   );

   qdec_position #(.POS_W(POS_W)) u_pos (
      .clk(clk), .rst(rst), .step_req(step_req), .err_req(err_req),
      .dir_req(dir_req), .pos(position), .step(step), .err(phase_err),
      .dir_q(dir_q)
   );

   assign dir_fwd = (dir_q == QD_FWD);

   p_reset_state_r9: assert property (@(posedge clk)
      rst |=> (position == '0 && dir_fwd && !step && !phase_err));

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      phase_err |-> (position == $past(position) && dir_fwd == $past(dir_fwd)));

endmodule

// File: tb/quad_position_decoder_test.sv
module quad_position_decoder_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         ch_a = 1'b0;
   logic         ch_b = 1'b0;
   logic [W-1:0] position;
   logic         step, dir_fwd, phase_err;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] exp_pos = '0;
   logic         exp_dir = 1'b1;

   always #10 clk = ~clk;   // 50 MHz

   quad_position_decoder #(.POS_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .ch_a(ch_a), .ch_b(ch_b),
      .position(position), .step(step), .dir_fwd(dir_fwd), .phase_err(phase_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Gray index: 00->0, 10->1, 11->2, 01->3 (R1)
   function automatic int gidx(input logic a, input logic b);
      case ({a, b})
         2'b00:   return 0;
         2'b10:   return 1;
         2'b11:   return 2;
         default: return 3;
      endcase
   endfunction

   task automatic apply(input logic na, input logic nb);
      int d;
      string tag;
      logic exp_step, exp_err;
      d = (gidx(na, nb) - gidx(ch_a, ch_b)) & 3;
      if (na == ch_a && nb != ch_b)      tag = (na == nb) ? "R2" : "R3";
      else if (na != ch_a && nb == ch_b) tag = (na == nb) ? "R4" : "R5";
      else if (na != ch_a)               tag = "R7";
      else                               tag = "R11";
      exp_step = (d == 1 || d == 3);
      exp_err  = (d == 2);
      if (d == 1) begin exp_pos = exp_pos + 1'b1; exp_dir = 1'b1; end
      if (d == 3) begin exp_pos = exp_pos - 1'b1; exp_dir = 1'b0; end
      ch_a = na;
      ch_b = nb;
      repeat (2) @(negedge clk);
      check("R10 no early step", {31'b0, step | phase_err}, 32'd0);
      @(negedge clk);
      check({tag, " step"}, {31'b0, step}, {31'b0, exp_step});
      check({tag, " phase_err"}, {31'b0, phase_err}, {31'b0, exp_err});
      check({tag, " position"}, {24'b0, position}, {24'b0, exp_pos});
      check({tag, " dir_fwd"}, {31'b0, dir_fwd}, {31'b0, exp_dir});
      @(negedge clk);
      check("R10 one-cycle pulse", {31'b0, step | phase_err}, 32'd0);
      check("R10 hold", {24'b0, position}, {24'b0, exp_pos});
   endtask

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] base;
      // R9: inputs high through reset, release must be quiet
      ch_a = 1'b1; ch_b = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R9 no step at release", {30'b0, step, phase_err}, 32'd0);
      end
      check("R9 position zero", {24'b0, position}, 32'd0);
      check("R9 dir forward", {31'b0, dir_fwd}, 32'd1);

      // R11: repeat current levels, nothing moves
      apply(1'b1, 1'b1);

      // Sweep: every transition from every state (R2..R5, R7)
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            if (i != j) begin
               apply(i[1], i[0]);
               apply(j[1], j[0]);
            end
         end
      end

      // R6: one full forward cycle moves +4
      apply(1'b0, 1'b0);
      base = exp_pos;
      apply(1'b1, 1'b0); apply(1'b1, 1'b1); apply(1'b0, 1'b1); apply(1'b0, 1'b0);
      check("R6 four counts per cycle", {24'b0, position - base}, 32'd4);
      base = position;
      apply(1'b0, 1'b1); apply(1'b1, 1'b1); apply(1'b1, 1'b0); apply(1'b0, 1'b0);
      check("R6 reverse cycle", {24'b0, base - position}, 32'd4);

      // R8: forward across the top of the range, then back across the bottom
      for (int k = 0; k < 75; k++) begin
         apply(1'b1, 1'b0); apply(1'b1, 1'b1); apply(1'b0, 1'b1); apply(1'b0, 1'b0);
      end
      check("R8 forward wrap", {24'b0, position}, {24'b0, exp_pos});
      for (int k = 0; k < 140; k++) begin
         apply(1'b0, 1'b1); apply(1'b1, 1'b1); apply(1'b1, 1'b0); apply(1'b0, 1'b0);
      end
      check("R8 reverse wrap", {24'b0, position}, {24'b0, exp_pos});

      // R9: reset mid-run clears the count and direction
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check("R9 reset clears position", {24'b0, position}, 32'd0);
      check("R9 reset dir forward", {31'b0, dir_fwd}, 32'd1);
      exp_pos = '0; exp_dir = 1'b1;
      apply(1'b0, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule